// File: doc/BRIEF.md
# Programmable Edge/Level Interrupt Controller

This block collects seven condition levels from a receiver and turns them into a pending-event register and one interrupt output. Each source has an enable bit and a two-bit trigger code. The code chooses whether the source records an event when its condition appears, when it goes away, or for as long as it is present. The enable bit decides whether the source can record anything at all.

The trigger code of a source is spread over two registers. One register holds the high bit of every source's code, and the other holds the low bit. A software read of the pending register returns its contents and clears it. The interrupt output is asserted while any enabled source has a pending bit. A separate two-bit field shapes the pin: active high, active low, or an open-drain style pull-down that drives low or releases.

Top module: `irq_trig_ctrl`

## Requirements
- R1: After reset, the enable, code-high, code-low and polarity registers and the pending register all read 00h. `irq_o` is 0 and `irq_oe` is 1.
- R2: Register addresses are: enable at 07h, code-high at 08h, code-low at 09h, polarity in bits [1:0] of 0Ah, and pending at 0Bh. Bit 7 of the enable and code registers always reads 0. `bus_rdata` is loaded at the clock edge that samples `bus_rd` and holds its value while no read is made.
- R3: The code of source i is {bit i of 08h, bit i of 09h}. Code 00 sets pending bit i one clock after the condition rises from 0 to 1. Code 11 behaves exactly like 00. The bit stays set until the pending register is read.
- R4: Code 01 sets pending bit i one clock after the condition falls from 1 to 0. The bit stays set until the pending register is read.
- R5: Code 10 sets pending bit i on every clock in which the condition is 1. After the condition has gone back to 0, the bit stays set until the pending register is read.
- R6: When enable bit i is 0, pending bit i stays 0 and source i does not affect the interrupt output. Clearing an enable bit also clears its pending bit.
- R7: A read of 0Bh returns the pending bits (source 6 in bit 6 down to source 0 in bit 0) and clears them. A trigger that occurs in the same cycle as the read leaves its bit set.
- R8: Let "active" mean that any enabled pending bit is set. Polarity 00 and 11 give `irq_o` = active with `irq_oe` = 1. Polarity 01 gives `irq_o` = not active with `irq_oe` = 1. Polarity 10 gives `irq_o` = 0 with `irq_oe` = active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_i | input | 7 | Condition levels, source 6 down to source 0 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt pin value |
| irq_oe | output | 1 | Interrupt pin drive enable |

## Verification
The embedded properties check several rules on every cycle:
- A rising or falling condition in the matching code always produces a trigger.
- A level-coded source that is enabled and present is pending on the next cycle.
- Pending bits never vanish except through a status read or a disabled source.
- A read with no concurrent trigger empties the register.
- The pin obeys the selected polarity.
- Read data holds between reads.

The bench scenarios show the rest: the split of the trigger code across two addresses, reserved code 11 matching code 00, the register readback masks, several sources firing together, and the ordering between a read and a trigger in the same cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam logic [7:0] ADR_ENABLE  = 8'h07;
    localparam logic [7:0] ADR_CODE_HI = 8'h08;
    localparam logic [7:0] ADR_CODE_LO = 8'h09;
    localparam logic [7:0] ADR_POLAR   = 8'h0A;
    localparam logic [7:0] ADR_PEND    = 8'h0B;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'b00,
        TRIG_FALL  = 2'b01,
        TRIG_LEVEL = 2'b10,
        TRIG_RSVD  = 2'b11
    } trig_code_e;

    typedef enum logic [1:0] {
        POL_HIGH = 2'b00,
        POL_LOW  = 2'b01,
        POL_OPEN = 2'b10,
        POL_RSVD = 2'b11
    } pin_pol_e;

endpackage

// File: rtl/irqc_trigger.sv
module irqc_trigger
    import irqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cond_i,
    input  trig_code_e code_i,
    output logic       fire_o
);

    typedef struct packed {
        logic prev;
    } trig_state_t;

    trig_state_t st_d, st_q;
    logic        rise_w, fall_w;

    always_comb begin
        st_d      = st_q;
        st_d.prev = cond_i;
        rise_w    = cond_i & ~st_q.prev;
        fall_w    = ~cond_i & st_q.prev;
        unique case (code_i)
            TRIG_FALL:  fire_o = fall_w;
            TRIG_LEVEL: fire_o = cond_i;
            default:    fire_o = rise_w;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_rise_fires_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((code_i == TRIG_RISE || code_i == TRIG_RSVD) && $rose(cond_i)) |-> fire_o)
        else $error("rising condition missed");

    p_fall_fires_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == TRIG_FALL && $fell(cond_i)) |-> fire_o)
        else $error("falling condition missed");

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned SRC_N  = 7,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [SRC_N-1:0]  pend_i,
    output logic [SRC_N-1:0]  enable_o,
    output logic [SRC_N-1:0]  code_hi_o,
    output logic [SRC_N-1:0]  code_lo_o,
    output pin_pol_e          pol_o,
    output logic              pend_clr_o,
    output logic [DATA_W-1:0] bus_rdata
);

    typedef struct packed {
        logic [SRC_N-1:0]  enable;
        logic [SRC_N-1:0]  code_hi;
        logic [SRC_N-1:0]  code_lo;
        pin_pol_e          pol;
        logic [DATA_W-1:0] rdata;
    } cfg_t;

    cfg_t              cfg_d, cfg_q;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:SRC_N];

    always_comb begin
        cfg_d  = cfg_q;
        rd_mux = '0;
        if (bus_wr) begin
            unique case (bus_addr[7:0])
                ADR_ENABLE:  cfg_d.enable  = bus_wdata[SRC_N-1:0];
                ADR_CODE_HI: cfg_d.code_hi = bus_wdata[SRC_N-1:0];
                ADR_CODE_LO: cfg_d.code_lo = bus_wdata[SRC_N-1:0];
                ADR_POLAR:   cfg_d.pol     = pin_pol_e'(bus_wdata[1:0]);
                default: ;
            endcase
        end
        unique case (bus_addr[7:0])
            ADR_ENABLE:  rd_mux[SRC_N-1:0] = cfg_q.enable;
            ADR_CODE_HI: rd_mux[SRC_N-1:0] = cfg_q.code_hi;
            ADR_CODE_LO: rd_mux[SRC_N-1:0] = cfg_q.code_lo;
            ADR_POLAR:   rd_mux[1:0]       = cfg_q.pol;
            ADR_PEND:    rd_mux[SRC_N-1:0] = pend_i;
            default: ;
        endcase
        if (bus_rd) cfg_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign enable_o   = cfg_q.enable;
    assign code_hi_o  = cfg_q.code_hi;
    assign code_lo_o  = cfg_q.code_lo;
    assign pol_o      = cfg_q.pol;
    assign bus_rdata  = cfg_q.rdata;
    assign pend_clr_o = bus_rd && (bus_addr[7:0] == ADR_PEND);

    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata))
        else $error("read data changed without a read");

endmodule

// File: rtl/irqc_pin.sv
module irqc_pin
    import irqc_pkg::*;
(
    input  pin_pol_e pol_i,
    input  logic     active_i,
    output logic     irq_o,
    output logic     irq_oe
);

    always_comb begin
        unique case (pol_i)
            POL_LOW: begin
                irq_o  = ~active_i;
                irq_oe = 1'b1;
            end
            POL_OPEN: begin
                irq_o  = 1'b0;
                irq_oe = active_i;
            end
            default: begin
                irq_o  = active_i;
                irq_oe = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/irq_trig_ctrl.sv
module irq_trig_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned SRC_N  = 7,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_N-1:0]  cond_i,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              irq_oe
);

    typedef struct packed {
        logic [SRC_N-1:0] pend;
    } pend_t;

    pend_t            pd_d, pd_q;
    logic [SRC_N-1:0] enable_q, code_hi_q, code_lo_q, fire_w;
    pin_pol_e         pol_q;
    logic             pend_clr, active_w;

    irqc_regs #(
        .SRC_N (SRC_N),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pend_i    (pd_q.pend),
        .enable_o  (enable_q),
        .code_hi_o (code_hi_q),
        .code_lo_o (code_lo_q),
        .pol_o     (pol_q),
        .pend_clr_o(pend_clr),
        .bus_rdata (bus_rdata)
    );

    for (genvar gi = 0; gi < SRC_N; gi++) begin : g_src
        irqc_trigger u_trig (
            .clk   (clk),
            .rst_n (rst_n),
            .cond_i(cond_i[gi]),
            .code_i(trig_code_e'({code_hi_q[gi], code_lo_q[gi]})),
            .fire_o(fire_w[gi])
        );

        p_level_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (enable_q[gi] && code_hi_q[gi] && !code_lo_q[gi] && cond_i[gi]) |=> pd_q.pend[gi])
            else $error("level source not pending");
    end

    always_comb begin
        pd_d      = pd_q;
        pd_d.pend = enable_q & (fire_w | (pd_q.pend & ~{SRC_N{pend_clr}}));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pd_q <= '0;
        else        pd_q <= pd_d;
    end

    assign active_w = |(pd_q.pend & enable_q);

    irqc_pin u_pin (
        .pol_i   (pol_q),
        .active_i(active_w),
        .irq_o   (irq_o),
        .irq_oe  (irq_oe)
    );

    p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pd_q.pend & ~$past(enable_q)) == '0)
        else $error("disabled source pending");

    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr && fire_w == '0) |=> pd_q.pend == '0)
        else $error("pending not cleared by read");

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_clr |=> ($past(pd_q.pend) & $past(enable_q) & ~pd_q.pend) == '0)
        else $error("pending bit dropped without read");

    p_pin_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_q == POL_HIGH || pol_q == POL_RSVD) |-> (irq_o == active_w && irq_oe))
        else $error("active-high pin wrong");

    p_pin_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_q == POL_OPEN) |-> (!irq_o && irq_oe == active_w))
        else $error("open-drain pin wrong");

endmodule

// File: tb/irq_trig_ctrl_test.sv
module irq_trig_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    // [4:3] trigger code, [2] condition before, [1] condition after, [0] expected pending
    localparam logic [4:0] VEC [NVEC] = '{
        5'b00_01_1, 5'b00_10_0, 5'b00_11_0,
        5'b01_01_0, 5'b01_10_1, 5'b01_11_0,
        5'b10_01_1, 5'b10_10_1, 5'b10_11_1,
        5'b11_01_1, 5'b11_10_0, 5'b11_11_0
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cond = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata;
    logic       irq_o, irq_oe;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    irq_trig_ctrl uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond_i   (cond),
        .bus_wr   (wr),
        .bus_rd   (rd),
        .bus_addr (addr),
        .bus_wdata(wdata),
        .bus_rdata(rdata),
        .irq_o    (irq_o),
        .irq_oe   (irq_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    initial begin
        logic [7:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // reset state
        chk("R1 irq_o", {7'b0, irq_o}, 8'h00);
        chk("R1 irq_oe", {7'b0, irq_oe}, 8'h01);
        for (int a = 7; a <= 11; a++) begin
            rd_reg(8'(a), v);
            chk("R1 reg reset", v, 8'h00);
        end

        // register map and readback widths
        wr_reg(8'h07, 8'hFF); rd_reg(8'h07, v); chk("R2 enable bit7", v, 8'h7F);
        wr_reg(8'h08, 8'h55); rd_reg(8'h08, v); chk("R2 code-high", v, 8'h55);
        wr_reg(8'h09, 8'hAA); rd_reg(8'h09, v); chk("R2 code-low", v, 8'h2A);
        wr_reg(8'h0A, 8'hFF); rd_reg(8'h0A, v); chk("R2 polarity", v, 8'h03);
        tick(2);
        chk("R2 rdata hold", rdata, 8'h03);
        wr_reg(8'h0A, 8'h00); wr_reg(8'h07, 8'h00);
        wr_reg(8'h08, 8'h00); wr_reg(8'h09, 8'h00);

        // vector table: R3 R4 R5 trigger codes
        for (int k = 0; k < NVEC; k++) begin
            int src;
            src = k % 7;
            wr_reg(8'h07, 8'h00);
            cond = '0;
            tick(2);
            wr_reg(8'h08, 8'(VEC[k][4]) << src);
            wr_reg(8'h09, 8'(VEC[k][3]) << src);
            wr_reg(8'h07, 8'h01 << src);
            cond[src] = VEC[k][2];
            tick(2);
            rd_reg(8'h0B, v);
            cond[src] = VEC[k][1];
            tick(2);
            chk("R3/R4/R5 vector irq", {7'b0, irq_o}, {7'b0, VEC[k][0]});
            rd_reg(8'h0B, v);
            chk("R3/R4/R5 vector pending", v, 8'(VEC[k][0]) << src);
        end
        wr_reg(8'h07, 8'h00);
        cond = '0;
        wr_reg(8'h08, 8'h00); wr_reg(8'h09, 8'h00);
        tick(2);

        // R6 disabled source blocked
        cond[2] = 1'b1;
        tick(2);
        chk("R6 disabled irq", {7'b0, irq_o}, 8'h00);
        rd_reg(8'h0B, v);
        chk("R6 disabled pending", v, 8'h00);
        cond = '0;
        tick(2);

        // R6 clearing enable clears pending
        wr_reg(8'h07, 8'h04);
        cond[2] = 1'b1;
        tick(2);
        chk("R6 enabled irq", {7'b0, irq_o}, 8'h01);
        wr_reg(8'h07, 8'h00);
        chk("R6 irq after disable", {7'b0, irq_o}, 8'h00);
        wr_reg(8'h07, 8'h04);
        rd_reg(8'h0B, v);
        chk("R6 pending after disable", v, 8'h00);
        cond = '0;
        tick(2);

        // R7 all sources, read clears
        wr_reg(8'h07, 8'h7F);
        cond = 7'h7F;
        tick(2);
        rd_reg(8'h0B, v); chk("R7 all sources", v, 8'h7F);
        rd_reg(8'h0B, v); chk("R7 cleared", v, 8'h00);
        wr_reg(8'h07, 8'h00);
        cond = '0;
        tick(2);

        // R7 / R5 read concurrent with level trigger
        wr_reg(8'h08, 8'h01); wr_reg(8'h09, 8'h00); wr_reg(8'h07, 8'h01);
        cond[0] = 1'b1;
        tick(2);
        rd_reg(8'h0B, v); chk("R5 level present", v, 8'h01);
        rd_reg(8'h0B, v); chk("R7 trigger wins over clear", v, 8'h01);
        cond[0] = 1'b0;
        tick(2);
        rd_reg(8'h0B, v); chk("R5 level held after pulse", v, 8'h01);
        rd_reg(8'h0B, v); chk("R5 level cleared", v, 8'h00);
        wr_reg(8'h07, 8'h00); wr_reg(8'h08, 8'h00);
        tick(2);

        // R8 polarity
        wr_reg(8'h07, 8'h01);
        cond[0] = 1'b1;
        tick(2);
        chk("R8 high pol", {6'b0, irq_o, irq_oe}, 8'h03);
        wr_reg(8'h0A, 8'h01); chk("R8 low pol active", {6'b0, irq_o, irq_oe}, 8'h01);
        wr_reg(8'h0A, 8'h02); chk("R8 open pol active", {6'b0, irq_o, irq_oe}, 8'h01);
        wr_reg(8'h0A, 8'h03); chk("R8 reserved pol", {6'b0, irq_o, irq_oe}, 8'h03);
        rd_reg(8'h0B, v);
        wr_reg(8'h0A, 8'h02); chk("R8 open pol idle", {6'b0, irq_o, irq_oe}, 8'h00);
        wr_reg(8'h0A, 8'h01); chk("R8 low pol idle", {6'b0, irq_o, irq_oe}, 8'h03);
        wr_reg(8'h0A, 8'h00); chk("R8 high pol idle", {6'b0, irq_o, irq_oe}, 8'h01);
        cond = '0;
        tick(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule